// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer and Read Port

This block is the digital half of a 16-bit successive-approximation analog-to-digital converter. Two active-low style control pins, a select pin and a read/convert pin, are brought into the internal clock domain. Their logical OR is watched for a falling edge, which marks a conversion request. A conversion then walks a result register from the most significant bit down to the least significant one. Each step presents a trial word to an external DAC and reads back a single comparator decision.

When the last bit is decided, the result is copied into an output latch as a two's complement code and the ready flag returns high. The stored word is shown on a 16-bit parallel port only while select is low and read/convert is high. A swap input exchanges the upper and lower byte lanes. If both control pins are still low when ready returns high, the next conversion starts at once.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts when the OR of `sel_n` and `rd_cnv`, after synchronisation, goes from 1 to 0. This covers `rd_cnv` falling while `sel_n` is low, and `sel_n` falling while `rd_cnv` is low. `ready` drops on the clock edge that acts on that fall.
- R2: During a conversion, `dac_word` is the offset-binary result decided so far, with the bit under test set to 1 and all lower bits 0. The first trial word is 16'h8000, and bits are tested from bit 15 down to bit 0.
- R3: Each bit is held for `CLK_PER_BIT` clocks and is then kept when `cmp_le` is 1 (trial not above the input) and cleared when it is 0.
- R4: A conversion that has started runs to its end, and start requests made during it have no effect on its length or its result.
- R5: `ready` is low for exactly 16*`CLK_PER_BIT`+1 clocks per conversion. It rises on the same edge that loads the output latch.
- R6: `bus_en` is 1 only when the synchronised `sel_n` is 0 and the synchronised `rd_cnv` is 1. Otherwise `bus_en` is 0 and `bus_data` is all zeros, standing for a floating bus.
- R7: With `byte_swap` low, `bus_data[15:8]` carries result bits 15..8 and `bus_data[7:0]` carries bits 7..0. With `byte_swap` high, the two bytes are exchanged.
- R8: The latched result is two's complement: it equals the offset-binary SAR word with bit 15 inverted.
- R9: If the synchronised `sel_n` and `rd_cnv` are both low when `ready` rises, `ready` stays high for one clock and a new conversion begins without any new edge.
- R10: After reset, `ready` is 1, `bus_en` is 0, `bus_data` is 0 and `dac_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low, asynchronous |
| rd_cnv | input | 1 | Read (high) / convert (low) control, asynchronous |
| byte_swap | input | 1 | Exchange the upper and lower bytes on the bus |
| cmp_le | input | 1 | Comparator: 1 when trial DAC value is not above the input |
| dac_word | output | 16 | Offset-binary trial word for the external DAC |
| ready | output | 1 | Low while converting; high when the latch holds new data |
| bus_en | output | 1 | Drive enable for the parallel data pads |
| bus_data | output | 16 | Parallel read data, zero while not enabled |

## Verification
The assertions assume the comparator answers combinationally from `dac_word`, and that the code it compares against stays still for the length of a conversion. The stimulus changes the target code only while `ready` is high. It holds every level on `sel_n` and `rd_cnv` for at least three clocks, so the two-flop synchroniser never misses a pulse and the reference model can track each edge. Start requests made in the middle of a conversion are applied on purpose, to show that they do not stretch the `ready` low time.

// File: rtl/sar_pkg.sv
// Package: shared types for the converter sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_LOAD = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
// sar_sync: brings the two asynchronous control pins into the clock domain.
// It reports the synchronised levels and a one-cycle flag when their OR falls.
// Assumes: STAGES >= 2; the pins idle high and are held longer than STAGES clocks.
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rd_cnv,
    output logic sel_s,
    output logic rdc_s,
    output logic or_low,
    output logic or_fall
);
    logic [STAGES-1:0] sel_pipe;
    logic [STAGES-1:0] rdc_pipe;
    logic              or_prev;
    logic              or_now;

    // Shift both pins through their synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_pipe <= '1;
            rdc_pipe <= '1;
        end else begin
            sel_pipe <= {sel_pipe[STAGES-2:0], sel_n};
            rdc_pipe <= {rdc_pipe[STAGES-2:0], rd_cnv};
        end
    end

    // Remember the previous ORed level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) or_prev <= 1'b1;
        else        or_prev <= or_now;
    end

    // Decode the synchronised levels.
    always_comb begin
        sel_s   = sel_pipe[STAGES-1];
        rdc_s   = rdc_pipe[STAGES-1];
        or_now  = sel_s | rdc_s;
        or_low  = ~or_now;
        or_fall = or_prev & ~or_now;
    end
endmodule

// File: rtl/sar_seq.sv
// sar_seq: successive-approximation sequencer.
// It clears the SAR on start, tests one bit per CLK_PER_BIT clocks from the
// MSB down, then spends one cycle in a load state before returning to idle.
// Assumes: cmp_le answers combinationally to trial within the same cycle.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CLK_PER_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  or_fall,
    input  logic                  or_low,
    input  logic                  cmp_le,
    output logic [DW-1:0]         trial,
    output logic [DW-1:0]         sar_bits,
    output logic [$clog2(DW)-1:0] bit_idx,
    output logic                  conv_act,
    output logic                  load_pulse,
    output logic                  ready
);
    localparam int IW = $clog2(DW);
    localparam int TW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(CLK_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_TOP   = IW'(DW - 1);

    sar_state_e    state;
    logic [TW-1:0] tick;
    logic          rearm;
    logic          start_go;

    // A start is a fresh OR fall, or both pins still low right after a load.
    always_comb begin
        start_go = (state == ST_IDLE) & (or_fall | (rearm & or_low));
    end

    // Main sequencing: state, bit pointer, per-bit tick counter and SAR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sar_bits <= '0;
            bit_idx  <= '0;
            tick     <= '0;
            ready    <= 1'b1;
            rearm    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    rearm <= 1'b0;
                    if (start_go) begin
                        state    <= ST_CONV;
                        sar_bits <= '0;
                        bit_idx  <= IDX_TOP;
                        tick     <= '0;
                        ready    <= 1'b0;
                    end
                end
                ST_CONV: begin
                    if (tick == TICK_LAST) begin
                        tick              <= '0;
                        sar_bits[bit_idx] <= cmp_le;
                        if (bit_idx == '0) state   <= ST_LOAD;
                        else               bit_idx <= bit_idx - 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_LOAD: begin
                    state <= ST_IDLE;
                    ready <= 1'b1;
                    rearm <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Trial word: decided bits plus the bit under test; zero outside conversion.
    always_comb begin
        conv_act   = (state == ST_CONV);
        load_pulse = (state == ST_LOAD);
        trial      = '0;
        if (conv_act) begin
            trial          = sar_bits;
            trial[bit_idx] = 1'b1;
        end
    end
endmodule

// File: rtl/sar_port.sv
// sar_port: result latch and parallel read port.
// It loads the SAR word as two's complement on load_pulse. It registers the
// drive enable from the synchronised pins and can exchange the byte lanes.
// Assumes: DW is even; disabled data reads as zero (the pad cell floats it).
module sar_port #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_pulse,
    input  logic [DW-1:0] sar_bits,
    input  logic          sel_s,
    input  logic          rdc_s,
    input  logic          byte_swap,
    output logic          bus_en,
    output logic [DW-1:0] bus_data
);
    localparam int HW = DW / 2;

    logic [DW-1:0] latch_q;
    logic [DW-1:0] swapped;
    logic          en_next;

    // Lane exchange, generated per bit.
    for (genvar g = 0; g < HW; g++) begin : g_lane
        assign swapped[g]      = latch_q[g + HW];
        assign swapped[g + HW] = latch_q[g];
    end

    // Read allowed when select is low and read/convert is high.
    always_comb en_next = ~sel_s & rdc_s;

    // Capture the result with the sign bit inverted.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (load_pulse) latch_q <= sar_bits ^ {1'b1, {(DW-1){1'b0}}};
    end

    // Register the bus enable and the selected lane order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_en   <= 1'b0;
            bus_data <= '0;
        end else begin
            bus_en   <= en_next;
            bus_data <= en_next ? (byte_swap ? swapped : latch_q) : '0;
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// sar_adc_ctrl: top of the converter's digital side.
// It synchronises the control pins, runs the SAR and presents the result.
// Assumes: an external comparator drives cmp_le from dac_word combinationally.
module sar_adc_ctrl #(
    parameter int DW          = 16,
    parameter int CLK_PER_BIT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          rd_cnv,
    input  logic          byte_swap,
    input  logic          cmp_le,
    output logic [DW-1:0] dac_word,
    output logic          ready,
    output logic          bus_en,
    output logic [DW-1:0] bus_data
);
    logic                  sel_s;
    logic                  rdc_s;
    logic                  or_low;
    logic                  or_fall;
    logic [DW-1:0]         sar_bits;
    logic [$clog2(DW)-1:0] bit_idx;
    logic                  conv_act;
    logic                  load_pulse;

    sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .rd_cnv  (rd_cnv),
        .sel_s   (sel_s),
        .rdc_s   (rdc_s),
        .or_low  (or_low),
        .or_fall (or_fall)
    );

    sar_seq #(.DW(DW), .CLK_PER_BIT(CLK_PER_BIT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .or_fall    (or_fall),
        .or_low     (or_low),
        .cmp_le     (cmp_le),
        .trial      (dac_word),
        .sar_bits   (sar_bits),
        .bit_idx    (bit_idx),
        .conv_act   (conv_act),
        .load_pulse (load_pulse),
        .ready      (ready)
    );

    sar_port #(.DW(DW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pulse (load_pulse),
        .sar_bits   (sar_bits),
        .sel_s      (sel_s),
        .rdc_s      (rdc_s),
        .byte_swap  (byte_swap),
        .bus_en     (bus_en),
        .bus_data   (bus_data)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// sar_adc_ctrl_chk: protocol checker bound into sar_adc_ctrl.
// Assumes: observes only; drives nothing.
module sar_adc_ctrl_chk #(
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ready,
    input logic                  conv_act,
    input logic                  load_pulse,
    input logic [DW-1:0]         dac_word,
    input logic [$clog2(DW)-1:0] bit_idx,
    input logic                  bus_en,
    input logic [DW-1:0]         bus_data
);
    a_r5_low_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_act |-> !ready);

    a_r5_rise_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(load_pulse));

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        conv_act |=> (conv_act || load_pulse));

    a_r2_test_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        conv_act |-> dac_word[bit_idx]);

    a_r2_lower_clear: assert property (@(posedge clk) disable iff (!rst_n)
        conv_act |-> ((dac_word & ~({DW{1'b1}} << bit_idx)) == '0));

    a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_act) |-> (bit_idx == ($clog2(DW))'(DW - 1)));

    a_r6_off_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_data == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .conv_act   (conv_act),
    .load_pulse (load_pulse),
    .dac_word   (dac_word),
    .bit_idx    (bit_idx),
    .bus_en     (bus_en),
    .bus_data   (bus_data)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
    localparam int CPB      = 2;
    localparam int CONV_LEN = 16 * CPB + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        rd_cnv = 1'b1;
    logic        byte_swap = 1'b0;
    logic [15:0] code = 16'h0000;
    logic        cmp_le;
    logic [15:0] dac_word;
    logic        ready;
    logic        bus_en;
    logic [15:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Comparator model: offset-binary trial against offset-binary target.
    assign cmp_le = (dac_word <= (code ^ 16'h8000));

    sar_adc_ctrl #(.DW(16), .CLK_PER_BIT(CPB), .SYNC_STAGES(2)) u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_cnv(rd_cnv),
        .byte_swap(byte_swap), .cmp_le(cmp_le), .dac_word(dac_word),
        .ready(ready), .bus_en(bus_en), .bus_data(bus_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    bit   m_s1c, m_s2c, m_s1r, m_s2r, m_prev;
    int   m_cnt;
    bit   m_ready, m_rearm, m_en;
    logic [15:0] m_latch, m_data;

    always @(posedge clk) begin
        bit fall;
        bit lowlvl;
        if (!rst_n) begin
            m_s1c = 1; m_s2c = 1; m_s1r = 1; m_s2r = 1; m_prev = 1;
            m_cnt = 0; m_ready = 1; m_rearm = 0; m_en = 0;
            m_latch = 16'h0; m_data = 16'h0;
        end else begin
            m_en   = !m_s2c && m_s2r;
            m_data = m_en ? (byte_swap ? {m_latch[7:0], m_latch[15:8]} : m_latch) : 16'h0;
            lowlvl = !(m_s2c || m_s2r);
            fall   = m_prev && lowlvl;
            if (m_cnt == 0) begin
                if (fall || (m_rearm && lowlvl)) begin
                    m_cnt = CONV_LEN; m_ready = 0;
                end
                m_rearm = 0;
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_latch = code; m_ready = 1; m_rearm = 1;
                end
            end
            m_prev = m_s2c || m_s2r;
            m_s2c = m_s1c; m_s1c = sel_n;
            m_s2r = m_s1r; m_s1r = rd_cnv;
        end
    end

    // Cycle-by-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(ready === m_ready, "R1 R4 R5 R9 ready", ready, m_ready);
            check(bus_en === m_en, "R6 bus_en", bus_en, m_en);
            check(bus_data === m_data, "R6 R7 R8 bus_data", bus_data, m_data);
            if (m_cnt == CONV_LEN)
                check(dac_word === 16'h8000, "R2 first trial", dac_word, 16'h8000);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for ready to fall (R1), then measure its low time (R5, R4).
    task automatic measure_conv(input string tag, input bit poke);
        int w = 0;
        int len = 0;
        while (ready !== 1'b0 && w < 20) begin step(1); w++; end
        check(ready === 1'b0, {tag, " R1 start seen"}, ready, 0);
        while (ready === 1'b0 && len < 200) begin
            if (poke && len == 8)  rd_cnv = 1'b0;
            if (poke && len == 12) rd_cnv = 1'b1;
            step(1); len++;
        end
        check(len == CONV_LEN, {tag, " R4 R5 low length"}, len, CONV_LEN);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        check(ready === 1'b1 && bus_en === 1'b0, "R10 reset ready/en", {ready, bus_en}, 2'b10);
        check(bus_data === 16'h0 && dac_word === 16'h0, "R10 reset data", bus_data, 0);

        // Mode with select held low, read/convert pulsed; extra request mid-run (R4).
        foreach (code[i]) ; // no-op keeps loop style uniform
        for (int k = 0; k < 4; k++) begin
            logic [15:0] vals [4] = '{16'h1234, 16'h7FFF, 16'h8000, 16'hFFFF};
            code = vals[k];
            byte_swap = 1'b0;
            sel_n = 1'b0; step(4);
            rd_cnv = 1'b0; step(3); rd_cnv = 1'b1;
            measure_conv("rc-mode", k[0]);
            step(4);
            check(bus_data === code, "R3 R8 result", bus_data, code);
            byte_swap = 1'b1; step(2);
            check(bus_data === {code[7:0], code[15:8]}, "R7 swapped", bus_data, {code[7:0], code[15:8]});
            byte_swap = 1'b0;
            sel_n = 1'b1; step(4);
            check(bus_en === 1'b0 && bus_data === 16'h0, "R6 deselected", bus_data, 0);
        end

        // Mode with read/convert low first, select falls to start.
        code = 16'h0000;
        rd_cnv = 1'b0; step(4);
        sel_n = 1'b0; step(3); sel_n = 1'b1; rd_cnv = 1'b1;
        measure_conv("cs-mode", 1'b0);
        step(3);
        check(bus_en === 1'b0, "R6 select high", bus_en, 0);
        sel_n = 1'b0; step(4);
        check(bus_data === 16'h0000, "R8 zero code", bus_data, 0);

        // Both pins held low across the end: immediate restart (R9).
        code = 16'hA5C3;
        sel_n = 1'b1; rd_cnv = 1'b1; step(4);
        sel_n = 1'b0; rd_cnv = 1'b0;
        measure_conv("rearm", 1'b0);
        check(ready === 1'b1, "R9 one high cycle", ready, 1);
        step(1);
        check(ready === 1'b0, "R9 restarted", ready, 0);
        rd_cnv = 1'b1;
        while (ready !== 1'b1) step(1);
        step(4);
        check(bus_data === 16'hA5C3, "R8 rearm result", bus_data, 16'hA5C3);

        sel_n = 1'b1; step(4);
        finish_run();
    end
endmodule